// File: doc/BRIEF.md
# Per-Warp Register Scoreboard

This block keeps, for every warp of a processing core, a record of which architectural registers still have a write on its way. The issue stage asks it, without waiting for a clock, whether a candidate instruction may go: the query names a warp, the destination register and up to two source registers, and the answer is a single "safe" bit. An instruction that reads a register with a write outstanding (read-after-write) or writes one that is already waiting for a write (write-after-write) is held back.

When an instruction is issued, its destination is marked through the reserve port; when its result is written back, the mark is removed through the release port. Since each warp holds a full bit vector of marks, one warp may have several instructions in flight, each writing a different register. Register 0 as a destination stands for "no result" and never takes a mark.

Top module: `warp_scoreboard`

## Requirements
- R1: After reset no register of any warp is marked, so every query reports safe (`chk_safe` = 1).
- R2: A reserve with `rsv_en` = 1 and a non-zero `rsv_reg` marks that register of warp `rsv_warp`; from the cycle after the clock edge, a query on that warp with the same destination reports unsafe.
- R3: A query reports unsafe when a source whose valid bit is 1 names a marked register of the queried warp; a source whose valid bit is 0 has no effect on the result.
- R4: A reservation affects only its own warp: queries on all other warps, with any register, are unchanged by it.
- R5: A release with `rel_en` = 1 removes the mark of `rel_reg` in warp `rel_warp`; from the cycle after the edge, queries that only hit that register report safe.
- R6: Any number of registers of one warp may be marked at once; releasing one leaves the others marked.
- R7: A reserve and a release in the same cycle both take effect, whether they name the same warp or different warps; when both name the same warp and register, the register stays marked.
- R8: Register 0 is never marked: a reserve of register 0 does nothing, and a query with destination 0 and no valid source always reports safe.
- R9: A release may only name a register that is currently marked; releasing an unmarked non-zero register is a protocol error flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears all marks |
| rsv_en | input | 1 | Reserve request (instruction issued) |
| rsv_warp | input | $clog2(NUM_WARPS) | Warp of the issued instruction |
| rsv_reg | input | $clog2(NUM_REGS) | Destination register to mark; 0 means none |
| rel_en | input | 1 | Release request (result written back) |
| rel_warp | input | $clog2(NUM_WARPS) | Warp of the written-back instruction |
| rel_reg | input | $clog2(NUM_REGS) | Register whose mark is removed |
| chk_warp | input | $clog2(NUM_WARPS) | Warp of the candidate instruction |
| chk_dst | input | $clog2(NUM_REGS) | Destination of the candidate; 0 means none |
| chk_src_a | input | $clog2(NUM_REGS) | First source register |
| chk_src_a_vld | input | 1 | First source is used |
| chk_src_b | input | $clog2(NUM_REGS) | Second source register |
| chk_src_b_vld | input | 1 | Second source is used |
| chk_safe | output | 1 | 1 when the candidate hits no marked register |

## Verification
The query answer is combinational, so it is due in the same cycle as the query inputs, and the bench reads it one nanosecond after setting them while no update is pending. A reserve or release takes effect at the rising edge that samples it and is first visible to queries in the following cycle; the bench drives updates on the falling edge and reads queries only after the next rising edge has passed. Full sweeps over every warp and register follow each directed update, and a long random walk against a bit-array model checks one query per cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // Default geometry: warps per core and architectural registers per warp.
   localparam int SB_DEF_WARPS = 8;
   localparam int SB_DEF_REGS  = 32;
   // Register index that stands for "no destination".
   localparam int SB_NULL_REG  = 0;
endpackage

// File: rtl/sb_row.sv
// One warp's pending-write vector: set on reserve, cleared on release,
// with a same-cycle set taking priority over a clear of the same bit.
module sb_row #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 32,
   parameter int WARP_ID   = 0,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rsv_en,
   input  logic [WID_W-1:0]    rsv_warp,
   input  logic [REG_W-1:0]    rsv_reg,
   input  logic                rel_en,
   input  logic [WID_W-1:0]    rel_warp,
   input  logic [REG_W-1:0]    rel_reg,
   output logic [NUM_REGS-1:0] pend
);
   localparam logic [NUM_REGS-1:0] ONE_BIT = NUM_REGS'(1);
   localparam logic [REG_W-1:0]    NULL_R  = REG_W'(sb_pkg::SB_NULL_REG);

   logic                hit_rsv, hit_rel;
   logic [NUM_REGS-1:0] set_mask, clr_mask, pend_nxt;

   always_comb begin
      hit_rsv  = rsv_en && (rsv_warp == WID_W'(WARP_ID)) && (rsv_reg != NULL_R);
      hit_rel  = rel_en && (rel_warp == WID_W'(WARP_ID));
      set_mask = hit_rsv ? (ONE_BIT << rsv_reg) : '0;
      clr_mask = hit_rel ? (ONE_BIT << rel_reg) : '0;
      pend_nxt = (pend & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end
endmodule

// File: rtl/sb_check.sv
// Combinational hazard test for one candidate instruction.
module sb_check #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 32,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int FLAT_W   = NUM_WARPS * NUM_REGS
) (
   input  logic [FLAT_W-1:0] pend_flat,
   input  logic [WID_W-1:0]  warp,
   input  logic [REG_W-1:0]  dst,
   input  logic [REG_W-1:0]  src_a,
   input  logic              src_a_vld,
   input  logic [REG_W-1:0]  src_b,
   input  logic              src_b_vld,
   output logic              safe
);
   logic [NUM_REGS-1:0] row;
   logic                waw_hit, raw_a, raw_b;

   always_comb begin
      row = '0;
      for (int w = 0; w < NUM_WARPS; w++) begin
         if (warp == WID_W'(w)) row = pend_flat[w*NUM_REGS +: NUM_REGS];
      end
      waw_hit = row[dst];
      raw_a   = src_a_vld & row[src_a];
      raw_b   = src_b_vld & row[src_b];
      safe    = ~(waw_hit | raw_a | raw_b);
   end
endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard
   import sb_pkg::*;
#(
   parameter int NUM_WARPS = SB_DEF_WARPS,
   parameter int NUM_REGS  = SB_DEF_REGS,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int FLAT_W   = NUM_WARPS * NUM_REGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rsv_en,
   input  logic [WID_W-1:0] rsv_warp,
   input  logic [REG_W-1:0] rsv_reg,
   input  logic             rel_en,
   input  logic [WID_W-1:0] rel_warp,
   input  logic [REG_W-1:0] rel_reg,
   input  logic [WID_W-1:0] chk_warp,
   input  logic [REG_W-1:0] chk_dst,
   input  logic [REG_W-1:0] chk_src_a,
   input  logic             chk_src_a_vld,
   input  logic [REG_W-1:0] chk_src_b,
   input  logic             chk_src_b_vld,
   output logic             chk_safe
);
   // Elaboration-time parameter checks.
   if (NUM_WARPS < 2 || (1 << WID_W) != NUM_WARPS) begin : g_bad_warps
      $error("warp_scoreboard: NUM_WARPS must be a power of two, at least 2");
   end
   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("warp_scoreboard: NUM_REGS must be a power of two, at least 2");
   end

   // Pending-write vectors, warp w in bits [w*NUM_REGS +: NUM_REGS].
   logic [FLAT_W-1:0] pend_flat;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      sb_row #(
         .NUM_WARPS (NUM_WARPS),
         .NUM_REGS  (NUM_REGS),
         .WARP_ID   (w)
      ) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .rsv_en   (rsv_en),
         .rsv_warp (rsv_warp),
         .rsv_reg  (rsv_reg),
         .rel_en   (rel_en),
         .rel_warp (rel_warp),
         .rel_reg  (rel_reg),
         .pend     (pend_flat[w*NUM_REGS +: NUM_REGS])
      );
   end

   sb_check #(
      .NUM_WARPS (NUM_WARPS),
      .NUM_REGS  (NUM_REGS)
   ) u_check (
      .pend_flat (pend_flat),
      .warp      (chk_warp),
      .dst       (chk_dst),
      .src_a     (chk_src_a),
      .src_a_vld (chk_src_a_vld),
      .src_b     (chk_src_b),
      .src_b_vld (chk_src_b_vld),
      .safe      (chk_safe)
   );
endmodule

// File: rtl/warp_scoreboard_sva.sv
module warp_scoreboard_sva #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 32,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int FLAT_W   = NUM_WARPS * NUM_REGS,
   localparam int IDX_W    = $clog2(FLAT_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsv_en,
   input logic [WID_W-1:0]  rsv_warp,
   input logic [REG_W-1:0]  rsv_reg,
   input logic              rel_en,
   input logic [WID_W-1:0]  rel_warp,
   input logic [REG_W-1:0]  rel_reg,
   input logic [FLAT_W-1:0] pend_flat
);
   logic [IDX_W-1:0]     rsv_idx, rel_idx;
   logic [NUM_WARPS-1:0] zero_col;
   logic                 rsv_live, rel_live, same_slot;

   assign rsv_idx   = IDX_W'(rsv_warp) * IDX_W'(NUM_REGS) + IDX_W'(rsv_reg);
   assign rel_idx   = IDX_W'(rel_warp) * IDX_W'(NUM_REGS) + IDX_W'(rel_reg);
   assign rsv_live  = rsv_en && (rsv_reg != '0);
   assign rel_live  = rel_en && (rel_reg != '0);
   assign same_slot = rsv_live && rel_live && (rsv_idx == rel_idx);

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_zero
      assign zero_col[w] = pend_flat[w*NUM_REGS];
   end

   // R2 / R7: a reserve is visible after the edge, even against a release.
   a_r2_reserve_marks: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_live |=> pend_flat[$past(rsv_idx)]);

   // R5: a release with no competing reserve clears the mark.
   a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_live && !same_slot) |=> !pend_flat[$past(rel_idx)]);

   // R8: register 0 is never marked in any warp.
   a_r8_null_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
      zero_col == '0);

   // R9: release only of a marked register.
   a_r9_release_marked: assert property (@(posedge clk) disable iff (!rst_n)
      rel_live |-> pend_flat[rel_idx]);

   // R4 / R6: with no update at all, the whole state holds.
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsv_en && !rel_en) |=> $stable(pend_flat));
endmodule

bind warp_scoreboard warp_scoreboard_sva #(
   .NUM_WARPS (NUM_WARPS),
   .NUM_REGS  (NUM_REGS)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsv_en    (rsv_en),
   .rsv_warp  (rsv_warp),
   .rsv_reg   (rsv_reg),
   .rel_en    (rel_en),
   .rel_warp  (rel_warp),
   .rel_reg   (rel_reg),
   .pend_flat (pend_flat)
);

// File: tb/warp_scoreboard_test.sv
`timescale 1ns/1ps
module warp_scoreboard_test;
   localparam int NW    = 8;
   localparam int NR    = 32;
   localparam int WID_W = 3;
   localparam int REG_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rsv_en = 1'b0, rel_en = 1'b0;
   logic [WID_W-1:0] rsv_warp = '0, rel_warp = '0, chk_warp = '0;
   logic [REG_W-1:0] rsv_reg = '0, rel_reg = '0;
   logic [REG_W-1:0] chk_dst = '0, chk_src_a = '0, chk_src_b = '0;
   logic             chk_src_a_vld = 1'b0, chk_src_b_vld = 1'b0;
   logic             chk_safe;

   int checks = 0;
   int failures = 0;
   bit model [NW][NR];

   always #5 clk = ~clk;

   warp_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) uut (
      .clk(clk), .rst_n(rst_n),
      .rsv_en(rsv_en), .rsv_warp(rsv_warp), .rsv_reg(rsv_reg),
      .rel_en(rel_en), .rel_warp(rel_warp), .rel_reg(rel_reg),
      .chk_warp(chk_warp), .chk_dst(chk_dst),
      .chk_src_a(chk_src_a), .chk_src_a_vld(chk_src_a_vld),
      .chk_src_b(chk_src_b), .chk_src_b_vld(chk_src_b_vld),
      .chk_safe(chk_safe)
   );

   task automatic check_q(int w, int d, int a, bit va, int b, bit vb, string req);
      bit exp_safe;
      chk_warp = WID_W'(w); chk_dst = REG_W'(d);
      chk_src_a = REG_W'(a); chk_src_a_vld = va;
      chk_src_b = REG_W'(b); chk_src_b_vld = vb;
      #1;
      exp_safe = !(model[w][d] || (va && model[w][a]) || (vb && model[w][b]));
      checks++;
      if (chk_safe !== exp_safe) begin
         failures++;
         $display("FAIL %s warp=%0d dst=%0d a=%0d/%0b b=%0d/%0b actual=%0b expected=%0b",
                  req, w, d, a, va, b, vb, chk_safe, exp_safe);
      end
   endtask

   task automatic check_fixed(int w, int d, int a, bit va, int b, bit vb, bit want, string req);
      chk_warp = WID_W'(w); chk_dst = REG_W'(d);
      chk_src_a = REG_W'(a); chk_src_a_vld = va;
      chk_src_b = REG_W'(b); chk_src_b_vld = vb;
      #1;
      checks++;
      if (chk_safe !== want) begin
         failures++;
         $display("FAIL %s warp=%0d dst=%0d actual=%0b expected=%0b", req, w, d, chk_safe, want);
      end
   endtask

   task automatic sweep(string req);
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++)
            check_q(w, r, 0, 1'b0, 0, 1'b0, req);
   endtask

   task automatic step(bit re, int rw, int rr, bit le, int lw, int lr);
      @(negedge clk);
      rsv_en = re; rsv_warp = WID_W'(rw); rsv_reg = REG_W'(rr);
      rel_en = le; rel_warp = WID_W'(lw); rel_reg = REG_W'(lr);
      @(posedge clk);
      #1;
      if (le && lr != 0) model[lw][lr] = 1'b0;
      if (re && rr != 0) model[rw][rr] = 1'b1;
      rsv_en = 1'b0; rel_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) model[w][r] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: everything safe after reset, fixed expectation
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) check_fixed(w, r, r, 1'b1, r, 1'b1, 1'b1, "R1");

      // R8: reserving register 0 on every warp does nothing
      for (int w = 0; w < NW; w++) step(1'b1, w, 0, 1'b0, 0, 0);
      for (int w = 0; w < NW; w++) check_fixed(w, 0, 0, 1'b0, 0, 1'b0, 1'b1, "R8");
      sweep("R8");

      // R2 and R4: one mark on warp 3 register 7, only that slot blocks
      step(1'b1, 3, 7, 1'b0, 0, 0);
      check_fixed(3, 7, 0, 1'b0, 0, 1'b0, 1'b0, "R2");
      sweep("R4");

      // R3: source hazards and valid bits
      check_fixed(3, 0, 7, 1'b1, 1, 1'b0, 1'b0, "R3");
      check_fixed(3, 0, 7, 1'b0, 1, 1'b0, 1'b1, "R3");
      check_fixed(3, 0, 2, 1'b1, 7, 1'b1, 1'b0, "R3");
      check_fixed(3, 0, 2, 1'b1, 7, 1'b0, 1'b1, "R3");
      check_fixed(2, 0, 7, 1'b1, 7, 1'b1, 1'b1, "R3");

      // R6: several outstanding marks, then release one
      step(1'b1, 3, 9, 1'b0, 0, 0);
      step(1'b1, 3, 31, 1'b0, 0, 0);
      step(1'b0, 0, 0, 1'b1, 3, 7);
      check_fixed(3, 7, 7, 1'b1, 7, 1'b1, 1'b1, "R5");
      check_fixed(3, 9, 0, 1'b0, 0, 1'b0, 1'b0, "R6");
      check_fixed(3, 1, 31, 1'b1, 0, 1'b0, 1'b0, "R6");
      sweep("R6");

      // R7: same cycle, different warps; same warp different regs; same reg
      step(1'b1, 5, 4, 1'b1, 3, 9);
      check_fixed(5, 4, 0, 1'b0, 0, 1'b0, 1'b0, "R7");
      check_fixed(3, 9, 0, 1'b0, 0, 1'b0, 1'b1, "R7");
      step(1'b1, 3, 10, 1'b1, 3, 31);
      check_fixed(3, 10, 0, 1'b0, 0, 1'b0, 1'b0, "R7");
      check_fixed(3, 31, 0, 1'b0, 0, 1'b0, 1'b1, "R7");
      step(1'b1, 3, 10, 1'b1, 3, 10);
      check_fixed(3, 10, 0, 1'b0, 0, 1'b0, 1'b0, "R7");
      sweep("R7");

      // R5: drain everything and confirm all safe
      for (int w = 0; w < NW; w++)
         for (int r = 1; r < NR; r++)
            if (model[w][r]) step(1'b0, 0, 0, 1'b1, w, r);
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) check_fixed(w, r, r, 1'b1, r, 1'b1, 1'b1, "R5");

      // R6: random walk against the model, legal releases only
      for (int i = 0; i < 3000; i++) begin
         int unsigned x, y, z;
         int lw, lr;
         x = $urandom; y = $urandom; z = $urandom;
         lw = int'(y % NW); lr = int'((y >> 3) % NR);
         step(x[8], int'(x % NW), int'((x >> 3) % NR), model[lw][lr], lw, lr);
         check_q(int'(z % NW), int'((z >> 3) % NR), int'((z >> 8) % NR), z[13],
                 int'((z >> 14) % NR), z[19], "R6");
      end
      sweep("R6");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule